// File: doc/BRIEF.md
# Memory Transaction Legality Checker

This block stands between the internal requesters of a memory subsystem and the external memory controller. Each cycle it can take one transaction descriptor. A descriptor carries the direction (read or write), the burst length in 32-bit words, the start word address and the class of the requester. The checker looks up the target address in a small table of address windows. Each window gives a base and a limit, a reserved flag and a flash flag. The checker then applies a fixed table of legal burst shapes. Legal descriptors go downstream unchanged. Illegal ones are consumed and dropped, and a one-cycle error pulse with a code reports them. A hit on a reserved window also raises an abort pulse.

The input and output both use valid/ready handshaking through a single register stage. The input is ready whenever the output register is empty or is being drained in the same cycle. So back-pressure from downstream reaches the input combinationally, with no extra buffering. While `out_ready` is low and a descriptor is held, the held descriptor stays stable and nothing new is accepted. The region table and the error and abort outputs are plain pins with no handshake.

The word offset within an aligned 8-word (32-byte) line is address bits [2:0] of the word address. Requester class codes are: 0 core, 1 DMA, 2 display, 3 cache line fill, 4 cache copyback. Codes 5 to 7 are undefined.

Top module: `txn_legality_chk`

## Requirements
- R1: A descriptor is taken on a rising edge where `in_valid` and `in_ready` are both high. `in_ready` is high exactly when `out_valid` is low or `out_ready` is high. While `out_valid` is high and `out_ready` is low, every output field holds its value.
- R2: A legal descriptor appears on the output one cycle after it is taken, with direction, length, address and class unchanged. `err_valid` stays low for it.
- R3: A length-1 read or write is legal at any word offset (address bits [2:0]) for class codes 0 to 4. Class codes 5 to 7 give the bad-length code 3 at every length.
- R4: A 4-word read is legal only at offsets 0 and 4 and only for class 1 or 2. An 8-word read is legal only at offset 0 and only for class 3.
- R5: Writes longer than one word are legal only as follows. Length 2 at offsets 0, 1, 2, 4, 5 or 6. Length 3 at offsets 0, 1, 4 or 5. Length 4 at offsets 0 or 4. All three only for class 1. Length 8 only at offset 0 and only for class 4.
- R6: No forwarded descriptor crosses an aligned 8-word boundary: offset plus length never exceeds 8.
- R7: An illegal descriptor is not forwarded. One cycle after it is taken, `err_valid` pulses for one cycle with `err_code` set as follows: 1 reserved window, 2 flash burst write, 3 bad length, 4 bad alignment. When several apply, the lowest code number wins. A length, or a length with a class, that no rule lists gives 3. A listed length and class at an unlisted offset gives 4.
- R8: A write with length other than 1 to a window whose flash flag is set gives code 2, whatever the class or offset. Reads from flash follow R3 and R4.
- R9: Any descriptor to a window whose reserved flag is set gives code 1 and an `abort_o` pulse in the same cycle as `err_valid`. `abort_o` is never high without code 1.
- R10: An address that matches no window is treated as present, non-flash, non-reserved memory: no abort, and only R3 to R5 apply.
- R11: Window i matches when `cfg_base[i] <= address <= cfg_limit[i]`, using word addresses with both bounds inclusive. Entry i occupies bits `[i*ADDR_W +: ADDR_W]`. If windows overlap, the lowest-numbered matching entry decides the flags.
- R12: After reset, `out_valid`, `err_valid` and `abort_o` are low and `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Descriptor offered |
| in_ready | output | 1 | Checker can take a descriptor |
| in_write | input | 1 | 1 = write, 0 = read |
| in_len | input | 4 | Burst length in words |
| in_addr | input | ADDR_W | Start word address |
| in_req | input | 3 | Requester class code |
| cfg_base | input | NUM_REGIONS*ADDR_W | Window base addresses |
| cfg_limit | input | NUM_REGIONS*ADDR_W | Window limit addresses (inclusive) |
| cfg_reserved | input | NUM_REGIONS | Per-window reserved flag |
| cfg_flash | input | NUM_REGIONS | Per-window flash flag |
| out_valid | output | 1 | Legal descriptor held for downstream |
| out_ready | input | 1 | Downstream takes the held descriptor |
| out_write | output | 1 | Forwarded direction |
| out_len | output | 4 | Forwarded length |
| out_addr | output | ADDR_W | Forwarded start word address |
| out_req | output | 3 | Forwarded requester class |
| err_valid | output | 1 | One-cycle illegal-descriptor pulse |
| err_code | output | 3 | Error code, valid with err_valid |
| abort_o | output | 1 | One-cycle reserved-window abort pulse |

## Verification
Two things can happen at the same clock edge: a held legal descriptor drains downstream, and an illegal descriptor is taken and produces an error pulse. The bench provokes this by stalling `out_ready` with a legal descriptor held while an illegal one waits at the input. It then raises `out_ready` and judges the next cycle: the output must be empty and the error pulse present with the right code. A back-to-back stream of legal, illegal and legal descriptors with the output always ready checks that an error pulse and a forwarded descriptor never overlap. The legality table is swept in full over direction, length, class, offset and five address windows (plain, shadowed by overlap, flash, reserved, unmapped). The expected verdict comes from an arithmetic half-line rule in the bench.

// File: rtl/txn_chk_pkg.sv
package txn_chk_pkg;
  localparam int LEN_W  = 4;
  localparam int OFF_W  = 3;
  localparam int REQ_W  = 3;
  localparam int CODE_W = 3;

  localparam logic [REQ_W-1:0] RQ_CORE     = 3'd0;
  localparam logic [REQ_W-1:0] RQ_DMA      = 3'd1;
  localparam logic [REQ_W-1:0] RQ_DISP     = 3'd2;
  localparam logic [REQ_W-1:0] RQ_FILL     = 3'd3;
  localparam logic [REQ_W-1:0] RQ_COPYBACK = 3'd4;

  typedef enum logic [CODE_W-1:0] {
    ERR_NONE     = 3'd0,
    ERR_RESERVED = 3'd1,
    ERR_FLASH    = 3'd2,
    ERR_LENGTH   = 3'd3,
    ERR_ALIGN    = 3'd4
  } err_code_e;
endpackage

// File: rtl/txn_region_map.sv
module txn_region_map #(
  parameter int ADDR_W      = 16,
  parameter int NUM_REGIONS = 4
) (
  input  logic [ADDR_W-1:0]             addr,
  input  logic [NUM_REGIONS*ADDR_W-1:0] cfg_base,
  input  logic [NUM_REGIONS*ADDR_W-1:0] cfg_limit,
  input  logic [NUM_REGIONS-1:0]        cfg_reserved,
  input  logic [NUM_REGIONS-1:0]        cfg_flash,
  output logic                          hit_reserved,
  output logic                          hit_flash
);
  logic [NUM_REGIONS-1:0] match;

  // one comparator pair per window
  generate
    for (genvar g = 0; g < NUM_REGIONS; g++) begin : g_win
      logic [ADDR_W-1:0] lo, hi;
      assign lo       = cfg_base[g*ADDR_W +: ADDR_W];
      assign hi       = cfg_limit[g*ADDR_W +: ADDR_W];
      assign match[g] = (addr >= lo) && (addr <= hi);
    end
  endgenerate

  // walk from the top so the lowest matching index has the last word (R11)
  always_comb begin
    hit_reserved = 1'b0;
    hit_flash    = 1'b0;
    for (int i = NUM_REGIONS - 1; i >= 0; i--) begin
      if (match[i]) begin
        hit_reserved = cfg_reserved[i];
        hit_flash    = cfg_flash[i];
      end
    end
  end
endmodule

// File: rtl/txn_rule_check.sv
module txn_rule_check
  import txn_chk_pkg::*;
(
  input  logic              is_write,
  input  logic [LEN_W-1:0]  len,
  input  logic [REQ_W-1:0]  req,
  input  logic [OFF_W-1:0]  offset,
  input  logic              in_reserved,
  input  logic              in_flash,
  output logic [CODE_W-1:0] code
);
  logic [7:0] off_mask;   // bit k set: offset k is allowed for this shape
  logic       cls_ok;

  always_comb begin
    off_mask = 8'h00;
    cls_ok   = 1'b0;
    case ({is_write, len})
      {1'b0, 4'd1},
      {1'b1, 4'd1}: begin off_mask = 8'hFF; cls_ok = (req <= RQ_COPYBACK); end
      {1'b0, 4'd4}: begin off_mask = 8'h11; cls_ok = (req == RQ_DMA) || (req == RQ_DISP); end
      {1'b0, 4'd8}: begin off_mask = 8'h01; cls_ok = (req == RQ_FILL); end
      {1'b1, 4'd2}: begin off_mask = 8'h77; cls_ok = (req == RQ_DMA); end
      {1'b1, 4'd3}: begin off_mask = 8'h33; cls_ok = (req == RQ_DMA); end
      {1'b1, 4'd4}: begin off_mask = 8'h11; cls_ok = (req == RQ_DMA); end
      {1'b1, 4'd8}: begin off_mask = 8'h01; cls_ok = (req == RQ_COPYBACK); end
      default: ;
    endcase

    if (in_reserved)                                code = ERR_RESERVED;
    else if (in_flash && is_write && len != 4'd1)   code = ERR_FLASH;
    else if (off_mask == 8'h00 || !cls_ok)          code = ERR_LENGTH;
    else if (!off_mask[offset])                     code = ERR_ALIGN;
    else                                            code = ERR_NONE;
  end
endmodule

// File: rtl/txn_legality_chk.sv
module txn_legality_chk
  import txn_chk_pkg::*;
#(
  parameter int ADDR_W      = 16,
  parameter int NUM_REGIONS = 4
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          in_valid,
  output logic                          in_ready,
  input  logic                          in_write,
  input  logic [LEN_W-1:0]              in_len,
  input  logic [ADDR_W-1:0]             in_addr,
  input  logic [REQ_W-1:0]              in_req,
  input  logic [NUM_REGIONS*ADDR_W-1:0] cfg_base,
  input  logic [NUM_REGIONS*ADDR_W-1:0] cfg_limit,
  input  logic [NUM_REGIONS-1:0]        cfg_reserved,
  input  logic [NUM_REGIONS-1:0]        cfg_flash,
  output logic                          out_valid,
  input  logic                          out_ready,
  output logic                          out_write,
  output logic [LEN_W-1:0]              out_len,
  output logic [ADDR_W-1:0]             out_addr,
  output logic [REQ_W-1:0]              out_req,
  output logic                          err_valid,
  output logic [CODE_W-1:0]             err_code,
  output logic                          abort_o
);
  localparam int SPAN_W = OFF_W + 2;

  logic              hit_reserved, hit_flash;
  logic [CODE_W-1:0] code;
  logic              accept;

  txn_region_map #(.ADDR_W(ADDR_W), .NUM_REGIONS(NUM_REGIONS)) u_map (
    .addr        (in_addr),
    .cfg_base    (cfg_base),
    .cfg_limit   (cfg_limit),
    .cfg_reserved(cfg_reserved),
    .cfg_flash   (cfg_flash),
    .hit_reserved(hit_reserved),
    .hit_flash   (hit_flash)
  );

  txn_rule_check u_rules (
    .is_write   (in_write),
    .len        (in_len),
    .req        (in_req),
    .offset     (in_addr[OFF_W-1:0]),
    .in_reserved(hit_reserved),
    .in_flash   (hit_flash),
    .code       (code)
  );

  assign in_ready = !out_valid || out_ready;
  assign accept   = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_write <= 1'b0;
      out_len   <= '0;
      out_addr  <= '0;
      out_req   <= '0;
      err_valid <= 1'b0;
      err_code  <= ERR_NONE;
      abort_o   <= 1'b0;
    end else begin
      err_valid <= accept && (code != ERR_NONE);
      err_code  <= accept ? code : ERR_NONE;
      abort_o   <= accept && (code == ERR_RESERVED);
      if (accept && code == ERR_NONE) begin
        out_valid <= 1'b1;
        out_write <= in_write;
        out_len   <= in_len;
        out_addr  <= in_addr;
        out_req   <= in_req;
      end else if (out_ready) begin
        out_valid <= 1'b0;
      end
    end
  end

  // R1
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_addr) && $stable(out_len)
                                && $stable(out_write) && $stable(out_req));
  // R1
  stall_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !in_ready);
  // R6
  no_cross_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> ({2'b00, out_addr[OFF_W-1:0]} + {1'b0, out_len}) <= SPAN_W'(8));
  // R7
  err_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_valid |-> !out_valid && err_code != ERR_NONE);
  // R7
  err_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_valid |=> !err_valid || $past(accept));
  // R8
  flash_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept && in_write && hit_flash && !hit_reserved && in_len != 4'd1
      |=> err_valid && err_code == ERR_FLASH);
  // R9
  abort_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    abort_o |-> err_valid && err_code == ERR_RESERVED);
endmodule

// File: tb/test_txn_legality_chk.sv
module test_txn_legality_chk;
  localparam int CLK_P = 10;
  localparam int AW    = 8;
  localparam int NR    = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0, in_write = 1'b0, out_ready = 1'b1;
  logic [3:0] in_len = '0;
  logic [AW-1:0] in_addr = '0;
  logic [2:0] in_req = '0;
  logic in_ready, out_valid, out_write, err_valid, abort_o;
  logic [3:0] out_len;
  logic [AW-1:0] out_addr;
  logic [2:0] out_req, err_code;

  // windows: 0 plain 00-3F, 1 flash 40-5F, 2 reserved 60-7F, 3 reserved 30-4F (fully shadowed)
  logic [NR*AW-1:0] cfg_base  = {8'h30, 8'h60, 8'h40, 8'h00};
  logic [NR*AW-1:0] cfg_limit = {8'h4F, 8'h7F, 8'h5F, 8'h3F};
  logic [NR-1:0]    cfg_reserved = 4'b1100;
  logic [NR-1:0]    cfg_flash    = 4'b0010;

  int n_chk = 0, n_fail = 0;

  always #(CLK_P/2) clk = ~clk;

  txn_legality_chk #(.ADDR_W(AW), .NUM_REGIONS(NR)) i_txn_legality_chk (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_write(in_write), .in_len(in_len), .in_addr(in_addr), .in_req(in_req),
    .cfg_base(cfg_base), .cfg_limit(cfg_limit), .cfg_reserved(cfg_reserved),
    .cfg_flash(cfg_flash), .out_valid(out_valid), .out_ready(out_ready),
    .out_write(out_write), .out_len(out_len), .out_addr(out_addr), .out_req(out_req),
    .err_valid(err_valid), .err_code(err_code), .abort_o(abort_o)
  );

  // 0 plain, 1 flash, 2 reserved (lowest window wins on overlap)
  function automatic int region_of(input logic [AW-1:0] a);
    if (a <= 8'h3F) return 0;
    if (a <= 8'h5F) return 1;
    if (a <= 8'h7F) return 2;
    return 0;
  endfunction

  function automatic logic [2:0] expect_code(input logic w, input int len, input int cls,
                                             input logic [AW-1:0] a);
    int off = int'(a[2:0]);
    int reg_k = region_of(a);
    logic shape_ok;
    logic pos_ok;
    if (reg_k == 2) return 3'd1;
    if (reg_k == 1 && w && len != 1) return 3'd2;
    if (cls > 4) return 3'd3;
    shape_ok = 1'b0;
    pos_ok   = 1'b0;
    if (len == 1) begin shape_ok = 1'b1; pos_ok = 1'b1; end
    else if (len == 8) begin
      shape_ok = w ? (cls == 4) : (cls == 3);
      pos_ok   = (off == 0);
    end else if (!w && len == 4) begin
      shape_ok = (cls == 1 || cls == 2);
      pos_ok   = (off % 4 + len <= 4);
    end else if (w && len >= 2 && len <= 4) begin
      shape_ok = (cls == 1);
      pos_ok   = (off % 4 + len <= 4);
    end
    if (!shape_ok) return 3'd3;
    if (!pos_ok) return 3'd4;
    return 3'd0;
  endfunction

  function automatic string tag_of(input logic w, input int len, input logic [AW-1:0] a);
    int reg_k = region_of(a);
    if (reg_k == 2) return "R9";
    if (reg_k == 1 && w && len != 1) return "R8";
    if (len == 1) return "R3";
    return w ? "R5" : "R4";
  endfunction

  task automatic report(input logic ok, input string tag, input string what,
                        input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // compare outputs against the verdict expected for descriptor (w,len,cls,a)
  task automatic judge(input logic w, input int len, input int cls,
                       input logic [AW-1:0] a, input string tag);
    logic [2:0] e = expect_code(w, len, cls, a);
    logic ok;
    if (e == 3'd0)
      ok = out_valid && !err_valid && !abort_o && out_write == w &&
           out_len == 4'(len) && out_req == 3'(cls) && out_addr == a;
    else
      ok = !out_valid && err_valid && !(err_code != e) && abort_o == (e == 3'd1);
    report(ok, tag, $sformatf("w%0d len%0d cls%0d addr%0h verdict", w, len, cls, a),
           {out_valid, err_valid, abort_o, err_code}, {(e == 0), (e != 0), (e == 1), e});
  endtask

  task automatic drive(input logic w, input int len, input int cls, input logic [AW-1:0] a);
    in_valid = 1'b1;
    in_write = w;
    in_len   = 4'(len);
    in_req   = 3'(cls);
    in_addr  = a;
  endtask

  task automatic send_check(input logic w, input int len, input int cls,
                            input logic [AW-1:0] a, input string tag);
    @(negedge clk);
    drive(w, len, cls, a);
    @(negedge clk);
    in_valid = 1'b0;
    judge(w, len, cls, a, tag);
  endtask

  initial begin
    #(CLK_P * 150000);
    n_fail++;
    $display("FAIL R1 watchdog: actual hung expected finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [AW-1:0] bases [5] = '{8'h10, 8'h38, 8'h48, 8'h68, 8'hA0};
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R12 reset state
    report(!out_valid && !err_valid && !abort_o && in_ready, "R12", "reset outputs",
           {out_valid, err_valid, abort_o, in_ready}, 4'b0001);

    // full sweep of the legality table (R2..R11)
    for (int b = 0; b < 5; b++)
      for (int w = 0; w < 2; w++)
        for (int len = 0; len < 16; len++)
          for (int cls = 0; cls < 8; cls++)
            for (int off = 0; off < 8; off++)
              send_check(1'(w), len, cls, bases[b] + AW'(off), tag_of(1'(w), len, bases[b]));

    // named corner cases
    send_check(1'b1, 2, 1, 8'h17, "R6");   // would cross the line -> alignment code 4
    send_check(1'b1, 8, 4, 8'h11, "R6");   // copyback off line start -> code 4
    send_check(1'b1, 5, 1, 8'h40, "R7");   // flash beats bad length: code 2
    send_check(1'b1, 5, 7, 8'h60, "R7");   // reserved beats all: code 1
    send_check(1'b0, 4, 0, 8'h14, "R7");   // class not allowed -> code 3
    send_check(1'b0, 8, 3, 8'h48, "R8");   // flash read burst is fine
    send_check(1'b1, 8, 4, 8'hA0, "R10");  // unmapped memory forwarded
    send_check(1'b1, 8, 4, 8'h38, "R11");  // overlap: plain window 0 wins
    send_check(1'b1, 2, 1, 8'h48, "R11");  // overlap: flash window 1 wins
    send_check(1'b0, 1, 0, 8'h6F, "R9");   // reserved single read aborts

    // back-pressure: hold legal A, offer illegal B, then release
    @(negedge clk);
    out_ready = 1'b0;
    drive(1'b1, 4, 1, 8'h04);
    @(negedge clk);
    drive(1'b1, 3, 1, 8'h06);              // B: alignment error
    report(out_valid && out_addr == 8'h04 && !in_ready, "R1", "stall load",
           {out_valid, in_ready}, 2'b10);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      report(out_valid && out_addr == 8'h04 && out_len == 4'd4 && !in_ready && !err_valid,
             "R1", "stall hold", {out_valid, in_ready, err_valid}, 3'b100);
    end
    out_ready = 1'b1;                      // A drains and B is taken at the same edge
    @(negedge clk);
    in_valid = 1'b0;
    judge(1'b1, 3, 1, 8'h06, "R7");

    // back-to-back stream: legal, illegal, legal
    @(negedge clk);
    drive(1'b0, 8, 3, 8'h20);
    @(negedge clk);
    judge(1'b0, 8, 3, 8'h20, "R2");
    drive(1'b1, 8, 1, 8'h20);
    @(negedge clk);
    judge(1'b1, 8, 1, 8'h20, "R7");
    drive(1'b1, 1, 0, 8'h23);
    @(negedge clk);
    in_valid = 1'b0;
    judge(1'b1, 1, 0, 8'h23, "R2");
    @(negedge clk);
    report(!out_valid && !err_valid, "R7", "quiet after stream",
           {out_valid, err_valid}, 2'b00);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end
endmodule